// File: doc/BRIEF.md
# Clock-Offset Monitor and Prefill Calculator

This block measures how far an incoming audio word clock runs from a local reference clock. It then works out how many frames a rate-decoupling buffer must hold before playback starts. The block runs entirely on the local reference clock. It counts reference cycles across a configurable number of word-clock periods, which is called a gate. It subtracts the count expected for the nominal rate, then turns the difference into a signed parts-per-million figure. From the same difference it derives the smallest prefill that keeps the buffer from running dry or overflowing over a chosen playback length.

The prefill is the drift accumulated over the target length, plus a fixed guard margin. It is limited to half the physical buffer depth. A downstream buffer controller uses this figure as its start threshold instead of a fixed half-depth, so latency stays as low as the measured offset allows. The result is flagged as trustworthy only when two back-to-back gates agree. The flag drops as soon as the word clock goes quiet for longer than one gate.

The word-clock input must already be synchronised to the reference clock. The configuration inputs are held steady while a measurement runs.

Top module: `clk_offset_prefill`

## Requirements
- R1: After reset, `offsetValid` is 0 and both `ppmOffset` and `prefillFrames` are 0.
- R2: The count of a gate is the number of reference cycles from the rising word-clock edge that opens it to the rising edge that ends the `cfgGateFrames`-th period after it. The first rising edge after reset or after a loss opens the first gate. Each closing edge also opens the next gate.
- R3: `ppmOffset` equals (count − `cfgNominal`) × 1,000,000 / `cfgNominal`, truncated toward zero and written as two's complement. It is positive when the count exceeds the nominal value. Its magnitude saturates at 2^(PPM_W−1) − 1.
- R4: `prefillFrames` equals floor(|count − `cfgNominal`| × `cfgTargetFrames` / `cfgNominal`) + GUARD_FRAMES, limited to DEPTH/2.
- R5: Every gate publishes new outputs. `offsetValid` is 1 only when the count just published differs by at most AGREE_TOL from the count published for the gate before it. The first gate after reset or after a loss is never valid.
- R6: If no rising word-clock edge arrives for `cfgNominal` reference cycles, `offsetValid` clears and the gate history is discarded. `ppmOffset` and `prefillFrames` keep their last published values.
- R7: The outputs change only when a result is published. Publication happens between 8 and 2×(CNT_W+TGT_W)+8 reference cycles after the closing edge of a gate, so the previous result stays visible until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lrckSync | input | 1 | Word clock, already synchronised to `clk` |
| cfgGateFrames | input | GATE_W | Word-clock periods per gate (at least 1) |
| cfgNominal | input | CNT_W | Expected reference cycles per gate; also the loss timeout |
| cfgTargetFrames | input | TGT_W | Target playback length in frames (rate × seconds) |
| ppmOffset | output | PPM_W | Signed offset in ppm |
| prefillFrames | output | $clog2(DEPTH) | Required buffer prefill in frames |
| offsetValid | output | 1 | Two consecutive gates agree and the word clock is present |

## Verification
The bench builds the block with PPM_W = 16, DEPTH = 1024, GUARD_FRAMES = 8 and AGREE_TOL = 2, and drives gates of 8 frames of roughly 32 cycles each. With a 16-bit offset, a count error of about 3 % saturates the ppm output. With a 512-frame ceiling, a long target length reaches the prefill clamp. Both corners are therefore hit with gates only a few hundred cycles long. Short gates also let the bench observe loss, agreement across three gates, and the hold of previous results before publication, all within a few thousand cycles.

// File: rtl/cop_pkg.sv
package cop_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic armGate;
    logic endGate;
    logic divStart;
    logic selFill;
    logic latchPpm;
    logic latchFill;
    logic publish;
    logic dropAll;
  } copStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic rise;
    logic gateFull;
    logic timeout;
    logic divBusy;
    logic divDone;
  } copStat_t;

  typedef enum logic {R_IDLE, R_GATE} runState_t;

  typedef enum logic [2:0] {
    C_IDLE, C_PPM_GO, C_PPM_WAIT, C_FILL_GO, C_FILL_WAIT, C_PUB
  } cmpState_t;

endpackage

// File: rtl/cop_divider.sv
module cop_divider #(
  parameter int NUM_W = 64,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int IW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem;
  logic [NUM_W-1:0] qsh;
  logic [IW-1:0]    left;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             ge;

  assign trial = {rem, qsh[NUM_W-1]};
  assign diff  = trial - {1'b0, den};
  assign ge    = trial >= {1'b0, den};
  assign quot  = qsh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem  <= '0;
      qsh  <= '0;
      left <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      rem  <= '0;
      qsh  <= num;
      left <= IW'(NUM_W);
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy) begin
      rem  <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      qsh  <= {qsh[NUM_W-2:0], ge};
      left <= left - IW'(1);
      if (left == IW'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  // R7: a finished division is announced exactly when the iteration stops
  p_div_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R3: partial remainder never reaches the divisor while iterating
  p_div_rem_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && den != '0 && !$past(start)) |-> (rem < den));

endmodule

// File: rtl/cop_ctrl.sv
module cop_ctrl
  import cop_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  copStat_t stat,
  output copStrb_t strb
);
  runState_t runState, runNext;
  cmpState_t cmpState, cmpNext;

  always_comb begin
    strb    = '0;
    runNext = runState;
    cmpNext = cmpState;
    if (stat.timeout) begin
      strb.dropAll = 1'b1;
      runNext      = R_IDLE;
      cmpNext      = C_IDLE;
    end else begin
      if (runState == R_IDLE) begin
        if (stat.rise) begin
          strb.armGate = 1'b1;
          runNext      = R_GATE;
        end
      end else if (stat.gateFull) begin
        strb.armGate = 1'b1;
        if (cmpState == C_IDLE) begin
          strb.endGate = 1'b1;
          cmpNext      = C_PPM_GO;
        end
      end
      case (cmpState)
        C_PPM_GO: begin
          strb.divStart = 1'b1;
          cmpNext       = C_PPM_WAIT;
        end
        C_PPM_WAIT: if (stat.divDone) begin
          strb.latchPpm = 1'b1;
          cmpNext       = C_FILL_GO;
        end
        C_FILL_GO: begin
          strb.divStart = 1'b1;
          strb.selFill  = 1'b1;
          cmpNext       = C_FILL_WAIT;
        end
        C_FILL_WAIT: if (stat.divDone) begin
          strb.latchFill = 1'b1;
          cmpNext        = C_PUB;
        end
        C_PUB: begin
          strb.publish = 1'b1;
          cmpNext      = C_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runState <= R_IDLE;
      cmpState <= C_IDLE;
    end else begin
      runState <= runNext;
      cmpState <= cmpNext;
    end
  end

  // R7: a division is only launched on an idle divider
  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.divStart |-> !stat.divBusy);

  // R7: publication always follows the prefill result by one cycle
  p_pub_order_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.publish |-> $past(strb.latchFill));

endmodule

// File: rtl/cop_datapath.sv
module cop_datapath
  import cop_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int GATE_W       = 16,
  parameter int TGT_W        = 32,
  parameter int PPM_W        = 24,
  parameter int FILL_W       = 21,
  parameter int DEPTH        = 2097152,
  parameter int GUARD_FRAMES = 64,
  parameter int AGREE_TOL    = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    lrckSync,
  input  logic [GATE_W-1:0]       cfgGateFrames,
  input  logic [CNT_W-1:0]        cfgNominal,
  input  logic [TGT_W-1:0]        cfgTargetFrames,
  input  copStrb_t                strb,
  output copStat_t                stat,
  output logic signed [PPM_W-1:0] ppmOut,
  output logic [FILL_W-1:0]       fillOut,
  output logic                    validOut
);
  localparam int NUM_W = CNT_W + TGT_W;
  localparam int HALF  = DEPTH / 2;
  localparam logic [NUM_W-1:0] PPM_SCALE = NUM_W'(1000000);
  localparam logic [NUM_W-1:0] PPM_MAX   = NUM_W'((64'd1 << (PPM_W - 1)) - 64'd1);

  logic              lrckPrev, rise;
  logic [CNT_W-1:0]  cycCnt, idleCnt, capCount, histCount;
  logic [GATE_W-1:0] frameCnt;
  logic              histValid;
  logic [CNT_W-1:0]  errMag, histDiff;
  logic              errNeg, agree;
  logic [NUM_W-1:0]  numMux, quot;
  logic              divBusy, divDone;
  logic [PPM_W-1:0]  magNarrow, ppmStage;
  logic [NUM_W:0]    fillSum;
  logic [FILL_W-1:0] fillStage;

  assign rise = lrckSync & ~lrckPrev;

  assign stat.rise     = rise;
  assign stat.gateFull = rise && ((frameCnt + GATE_W'(1)) == cfgGateFrames);
  assign stat.timeout  = !rise && (idleCnt >= cfgNominal);
  assign stat.divBusy  = divBusy;
  assign stat.divDone  = divDone;

  // gate and idle counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lrckPrev <= 1'b0;
      cycCnt   <= '0;
      frameCnt <= '0;
      idleCnt  <= '0;
      capCount <= '0;
    end else begin
      lrckPrev <= lrckSync;
      if (strb.armGate) begin
        cycCnt   <= '0;
        frameCnt <= '0;
      end else begin
        if (cycCnt != '1) cycCnt <= cycCnt + CNT_W'(1);
        if (rise)         frameCnt <= frameCnt + GATE_W'(1);
      end
      if (rise)                idleCnt <= '0;
      else if (idleCnt != '1)  idleCnt <= idleCnt + CNT_W'(1);
      if (strb.endGate)        capCount <= cycCnt + CNT_W'(1);
    end
  end

  assign errNeg   = capCount < cfgNominal;
  assign errMag   = errNeg ? (cfgNominal - capCount) : (capCount - cfgNominal);
  assign histDiff = (capCount >= histCount) ? (capCount - histCount) : (histCount - capCount);
  assign agree    = histValid && (histDiff <= CNT_W'(AGREE_TOL));
  assign numMux   = NUM_W'(errMag) * (strb.selFill ? NUM_W'(cfgTargetFrames) : PPM_SCALE);

  cop_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W)) div_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (strb.divStart),
    .num   (numMux),
    .den   (cfgNominal),
    .busy  (divBusy),
    .done  (divDone),
    .quot  (quot)
  );

  assign magNarrow = (quot > PPM_MAX) ? PPM_MAX[PPM_W-1:0] : quot[PPM_W-1:0];
  assign fillSum   = {1'b0, quot} + (NUM_W+1)'(GUARD_FRAMES);

  // staging and published results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ppmStage  <= '0;
      fillStage <= '0;
      ppmOut    <= '0;
      fillOut   <= '0;
      validOut  <= 1'b0;
      histCount <= '0;
      histValid <= 1'b0;
    end else begin
      if (strb.latchPpm)
        ppmStage <= errNeg ? (~magNarrow + PPM_W'(1)) : magNarrow;
      if (strb.latchFill)
        fillStage <= (fillSum > (NUM_W+1)'(HALF)) ? FILL_W'(HALF) : fillSum[FILL_W-1:0];
      if (strb.dropAll) begin
        validOut  <= 1'b0;
        histValid <= 1'b0;
      end else if (strb.publish) begin
        ppmOut    <= ppmStage;
        fillOut   <= fillStage;
        validOut  <= agree;
        histCount <= capCount;
        histValid <= 1'b1;
      end
    end
  end

  // R4: prefill never exceeds half the buffer
  p_fill_clamp_r4: assert property (@(posedge clk) disable iff (!rstN)
    fillOut <= FILL_W'(HALF));

  // R6: a quiet word clock removes the valid flag on the next cycle
  p_loss_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    stat.timeout |=> !validOut);

  // R7: results move only on publication
  p_hold_ppm_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.publish |=> ($stable(ppmOut) && $stable(fillOut)));

  // R5: valid can only rise with a previous gate on record
  p_valid_hist_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validOut) |-> $past(histValid));

endmodule

// File: rtl/clk_offset_prefill.sv
module clk_offset_prefill
  import cop_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int GATE_W       = 16,
  parameter int TGT_W        = 32,
  parameter int PPM_W        = 24,
  parameter int DEPTH        = 2097152,
  parameter int GUARD_FRAMES = 64,
  parameter int AGREE_TOL    = 4,
  localparam int FILL_W      = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    lrckSync,
  input  logic [GATE_W-1:0]       cfgGateFrames,
  input  logic [CNT_W-1:0]        cfgNominal,
  input  logic [TGT_W-1:0]        cfgTargetFrames,
  output logic signed [PPM_W-1:0] ppmOffset,
  output logic [FILL_W-1:0]       prefillFrames,
  output logic                    offsetValid
);
  copStrb_t strb;
  copStat_t stat;

  cop_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .strb (strb)
  );

  cop_datapath #(
    .CNT_W(CNT_W), .GATE_W(GATE_W), .TGT_W(TGT_W), .PPM_W(PPM_W),
    .FILL_W(FILL_W), .DEPTH(DEPTH), .GUARD_FRAMES(GUARD_FRAMES),
    .AGREE_TOL(AGREE_TOL)
  ) dp_i (
    .clk             (clk),
    .rstN            (rstN),
    .lrckSync        (lrckSync),
    .cfgGateFrames   (cfgGateFrames),
    .cfgNominal      (cfgNominal),
    .cfgTargetFrames (cfgTargetFrames),
    .strb            (strb),
    .stat            (stat),
    .ppmOut          (ppmOffset),
    .fillOut         (prefillFrames),
    .validOut        (offsetValid)
  );

endmodule

// File: tb/clk_offset_prefill_tb_top.sv
module clk_offset_prefill_tb_top;
  localparam int CNT_W = 32, GATE_W = 16, TGT_W = 32, PPM_W = 16;
  localparam int DEPTH = 1024, GUARD = 8, TOL = 2, GATES = 8;
  localparam int FILL_W = $clog2(DEPTH);
  localparam longint PPM_LIM = (64'd1 << (PPM_W - 1)) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic lrck = 1'b0;
  logic [GATE_W-1:0] cfgGate = GATE_W'(GATES);
  logic [CNT_W-1:0]  cfgNom  = 256;
  logic [TGT_W-1:0]  cfgTgt  = 1000;
  logic signed [PPM_W-1:0] ppm;
  logic [FILL_W-1:0] fill;
  logic valid;

  int testCnt = 0, failCnt = 0;
  longint heldPpm = 0, heldFill = 0;
  bit finished = 0;

  clk_offset_prefill #(.CNT_W(CNT_W), .GATE_W(GATE_W), .TGT_W(TGT_W), .PPM_W(PPM_W),
    .DEPTH(DEPTH), .GUARD_FRAMES(GUARD), .AGREE_TOL(TOL)) dut_i (
    .clk(clk), .rstN(rstN), .lrckSync(lrck), .cfgGateFrames(cfgGate),
    .cfgNominal(cfgNom), .cfgTargetFrames(cfgTgt),
    .ppmOffset(ppm), .prefillFrames(fill), .offsetValid(valid));

  function automatic longint expPpm(longint c, longint nom);
    longint e = c - nom;
    longint m = ((e < 0) ? -e : e) * 1000000 / nom;
    if (m > PPM_LIM) m = PPM_LIM;
    return (e < 0) ? -m : m;
  endfunction

  function automatic longint expFill(longint c, longint nom, longint tgt);
    longint e = (c < nom) ? nom - c : c - nom;
    longint f = e * tgt / nom + GUARD;
    return (f > DEPTH / 2) ? DEPTH / 2 : f;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendPeriod(input int p);
    lrck = 1'b1; tick(p / 2);
    lrck = 1'b0; tick(p - p / 2);
  endtask

  task automatic sendGate(input int c);
    for (int i = 0; i < GATES; i++) sendPeriod(c / GATES + ((i < c % GATES) ? 1 : 0));
  endtask

  // runs n gates (1..3) with counts c[0..n-1], then checks and lets the clock die
  task automatic scen(input int n, input int c0, input int c1, input int c2);
    int c[3];
    longint lastP, lastF;
    c[0] = c0; c[1] = c1; c[2] = c2;
    lastP = heldPpm; lastF = heldFill;
    for (int g = 0; g < n; g++) begin
      sendGate(c[g]);
      if (g < n - 1) begin
        lastP = expPpm(c[g], cfgNom);
        lastF = expFill(c[g], cfgNom, cfgTgt);
      end
    end
    lrck = 1'b1; tick(8); lrck = 1'b0;   // closing edge of the last gate
    chk("R7 ppm held before publish", ppm, lastP);
    chk("R7 prefill held before publish", fill, lastF);
    tick(180);
    heldPpm  = expPpm(c[n-1], cfgNom);
    heldFill = expFill(c[n-1], cfgNom, cfgTgt);
    chk("R3 ppm from R2 gate count", ppm, heldPpm);
    chk("R4 prefill", fill, heldFill);
    chk("R5 valid", valid,
        (n > 1 && ((c[n-1] > c[n-2]) ? c[n-1] - c[n-2] : c[n-2] - c[n-1]) <= TOL) ? 1 : 0);
    tick(int'(cfgNom) + 30);
    chk("R6 valid after loss", valid, 0);
    chk("R6 ppm kept after loss", ppm, heldPpm);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    tick(5);
    chk("R1 valid at reset", valid, 0);
    chk("R1 ppm at reset", ppm, 0);
    chk("R1 prefill at reset", fill, 0);
    rstN = 1'b1; tick(3);
    // exact nominal: zero offset, guard only
    scen(2, 256, 256, 0);
    // disagreeing pair
    scen(2, 250, 255, 0);
    // disagree then agree over three gates
    scen(3, 262, 250, 252);
    // single gate after loss matching the previous one
    scen(1, 252, 0, 0);
    // saturation both ways
    scen(2, 290, 290, 0);
    scen(2, 222, 222, 0);
    // clamp of the prefill
    cfgTgt = 200000;
    scen(2, 259, 259, 0);
    // randomised offsets
    for (int k = 0; k < 12; k++) begin
      int a, b;
      cfgNom = CNT_W'($urandom_range(240, 280));
      cfgTgt = TGT_W'($urandom_range(0, 40000));
      a = int'(cfgNom) + $urandom_range(0, 14) - 7;
      b = a + $urandom_range(0, 6) - 3;
      scen(2, a, b, 0);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule